// File: doc/BRIEF.md
# Per-Port Byte Rate Limiter

This block caps the byte rate of one switch port. Receive and transmit each have their own budget. Time is split into windows of a fixed length, and a window is a set number of pulses on a prescaled timebase input. Each frame reports its byte count at its start strobe. If the frame is allowed in, its bytes are added to the counter for its direction and priority class. Once a counter goes above its budget, later frames of that class are refused until the next window begins. The frame that crosses the budget is still admitted, so a frame in progress always finishes. When priority mode is on, high-priority and low-priority frames draw on separate budgets.

The budget for one window is the rate setting multiplied by `BYTES_PER_UNIT`. With the default of 4000 bytes per unit and a one-second window, one unit of the setting equals 32 kbps. A setting of zero means no limit. On the receive side the block can also raise a flow-control request before the budget is used up. The warning margin depends on the setting:
- For a setting of `SPLIT_UNITS` or more (128 kbps and above), the margin is `HI_MARGIN` (8192 bytes).
- For a smaller setting, the margin is `LO_MARGIN` (2048 bytes).

Each of the four counters (direction × class) has its own state machine with three states:
- `BK_OPEN`: under the warning line.
- `BK_NEAR`: inside the warning margin.
- `BK_OVER`: past the budget.

The transitions are:
- OPEN→NEAR: a counted frame lands within the margin without going over.
- OPEN→OVER and NEAR→OVER: a counted frame goes past the budget.
- NEAR→NEAR and OVER→OVER: the state holds for the rest of the window.
- Window restart: every state returns to OPEN, and the counter returns to zero.

If a frame is counted in the same cycle as a restart, it is evaluated from OPEN with a zero count.

Top module: `port_rate_limiter`

## Requirements
- R1: After reset, `rx_block`, `tx_block` and `fc_req` are all 0.
- R2: When a window ends, every counter is cleared. Both block vectors and `fc_req` read 0 from the next cycle, and frames are admitted again.
- R3: A window lasts exactly `WINDOW_TICKS` cycles with `tick` high, counted from the release of reset. Cycles with `tick` low do not advance the window.
- R4: `frame_dir`=0 marks a receive frame. The frame is admitted (`admit`=1 in its start cycle) and counted while its class is not blocked. Once the class count exceeds setting×`BYTES_PER_UNIT`, its `rx_block` bit is 1 from the next cycle, and later receive frames of that class see `admit`=0 until the window ends.
- R5: `frame_dir`=1 marks a transmit frame. It follows the same rule against `tx_rate_*` and `tx_block`. Receive traffic never changes transmit blocking, and transmit traffic never changes receive blocking.
- R6: The frame that takes a count past the budget is admitted in full. A count exactly equal to the budget does not block.
- R7: With `fc_en`=1 and a receive setting of 4 units or more, `fc_req` is 1 from the cycle after a counted receive frame brings count+8192 to or above the budget.
- R8: With `fc_en`=1 and a receive setting below 4 units, the margin used for `fc_req` is 2048 bytes.
- R9: With `fc_en`=0, `fc_req` stays 0.
- R10: A rate setting of 0 never blocks, whatever the byte count.
- R11: With `prio_en`=1, class 1 (`frame_prio`=1) is counted against `*_rate_hi` and reported on block bit 1. Class 0 is counted against `*_rate_lo` and reported on bit 0. The two classes keep separate counts.
- R12: With `prio_en`=0, every frame is counted against `*_rate_lo`, and both bits of a block vector show that one budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timebase pulse; the window counts these |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| frame_dir | input | 1 | 0 = receive, 1 = transmit |
| frame_prio | input | 1 | 1 = high-priority frame |
| frame_len | input | LEN_W | Byte count of the frame |
| prio_en | input | 1 | Separate budgets per priority class |
| fc_en | input | 1 | Enable the receive flow-control request |
| rx_rate_lo | input | RATE_W | Receive setting, class 0 (units of 32 kbps) |
| rx_rate_hi | input | RATE_W | Receive setting, class 1 |
| tx_rate_lo | input | RATE_W | Transmit setting, class 0 |
| tx_rate_hi | input | RATE_W | Transmit setting, class 1 |
| admit | output | 1 | The current start strobe is accepted and counted |
| rx_block | output | 2 | Receive refusal per class (bit 1 = high) |
| tx_block | output | 2 | Transmit refusal per class (bit 1 = high) |
| fc_req | output | 1 | Receive flow-control request |

## Verification
The bench builds the limiter with `WINDOW_TICKS` set to 2000 and leaves every other parameter at its default. This keeps a whole window inside a short run, so the bench can observe a window rollover that releases both blocking and flow control. It can also step the window one tick at a time and confirm the restart lands on the exact tick. The defaults keep 4000 bytes per unit and the real 8192 and 2048 byte margins. Frames of up to 2047 bytes therefore reach the warning line, an exactly-full budget and an overrun within a few frames, for both margin sizes.

// File: rtl/rl_pkg.sv
package rl_pkg;

    // Per-bucket occupancy state within one window
    typedef enum logic [1:0] {
        BK_OPEN = 2'd0,
        BK_NEAR = 2'd1,
        BK_OVER = 2'd2
    } bucket_state_e;

endpackage

// File: rtl/rl_window.sv
module rl_window #(
    parameter int WINDOW_TICKS = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic restart
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        restart = tick && (cnt == LAST);
    end

endmodule

// File: rtl/rl_bucket.sv
module rl_bucket
    import rl_pkg::*;
#(
    parameter int RATE_W         = 12,
    parameter int LEN_W          = 11,
    parameter int CNT_W          = 25,
    parameter int BYTES_PER_UNIT = 4000,
    parameter int SPLIT_UNITS    = 4,
    parameter int HI_MARGIN      = 8192,
    parameter int LO_MARGIN      = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              add,
    input  logic [LEN_W-1:0]  len,
    input  logic [RATE_W-1:0] rate,
    output logic              near,
    output logic              over
);
    localparam int SW = CNT_W + 1;

    bucket_state_e state, cur, nxt;
    logic [CNT_W-1:0] count, base, next_cnt, budget, margin;
    logic [SW-1:0]    sum;
    logic             limited, exceed, close;

    // Arithmetic for the frame under evaluation
    always_comb begin
        base     = restart ? '0 : count;
        sum      = {1'b0, base} + SW'(len);
        next_cnt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        budget   = CNT_W'(rate) * CNT_W'(BYTES_PER_UNIT);
        margin   = (rate < RATE_W'(SPLIT_UNITS)) ? CNT_W'(LO_MARGIN) : CNT_W'(HI_MARGIN);
        limited  = (rate != '0);
        exceed   = limited && (next_cnt > budget);
        close    = limited && (({1'b0, next_cnt} + {1'b0, margin}) >= {1'b0, budget});
    end

    // Next-state decision; a restart evaluates from OPEN
    always_comb begin
        cur = restart ? BK_OPEN : state;
        nxt = cur;
        unique case (cur)
            BK_OPEN: begin
                if (add) begin
                    if (exceed)     nxt = BK_OVER;
                    else if (close) nxt = BK_NEAR;
                    else            nxt = BK_OPEN;
                end
            end
            BK_NEAR: begin
                if (add && exceed) nxt = BK_OVER;
            end
            BK_OVER: nxt = BK_OVER;
            default: nxt = BK_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BK_OPEN;
        else        state <= nxt;
    end

    // Byte counter
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (add)     count <= next_cnt;
        else if (restart) count <= '0;
    end

    // Outputs
    always_comb begin
        near = (state != BK_OPEN);
        over = (state == BK_OVER);
    end

endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter #(
    parameter int WINDOW_TICKS   = 1_000_000,
    parameter int RATE_W         = 12,
    parameter int LEN_W          = 11,
    parameter int BYTES_PER_UNIT = 4000,
    parameter int SPLIT_UNITS    = 4,
    parameter int HI_MARGIN      = 8192,
    parameter int LO_MARGIN      = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              frame_start,
    input  logic              frame_dir,
    input  logic              frame_prio,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              prio_en,
    input  logic              fc_en,
    input  logic [RATE_W-1:0] rx_rate_lo,
    input  logic [RATE_W-1:0] rx_rate_hi,
    input  logic [RATE_W-1:0] tx_rate_lo,
    input  logic [RATE_W-1:0] tx_rate_hi,
    output logic              admit,
    output logic [1:0]        rx_block,
    output logic [1:0]        tx_block,
    output logic              fc_req
);
    localparam int CNT_W = $clog2(((1 << RATE_W) - 1) * BYTES_PER_UNIT + (1 << LEN_W)) + 1;

    logic       win_restart;
    logic       cls;
    logic [3:0] near_f, over_f;   // index = dir*2 + class
    logic [RATE_W-1:0] rate_sel [4];

    rl_window #(.WINDOW_TICKS(WINDOW_TICKS)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (win_restart)
    );

    always_comb begin
        rate_sel[0] = rx_rate_lo;
        rate_sel[1] = rx_rate_hi;
        rate_sel[2] = tx_rate_lo;
        rate_sel[3] = tx_rate_hi;
        cls         = prio_en & frame_prio;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        for (genvar c = 0; c < 2; c++) begin : g_cls
            logic add_here;
            assign add_here = admit && (frame_dir == (d != 0)) && (cls == (c != 0));
            rl_bucket #(
                .RATE_W         (RATE_W),
                .LEN_W          (LEN_W),
                .CNT_W          (CNT_W),
                .BYTES_PER_UNIT (BYTES_PER_UNIT),
                .SPLIT_UNITS    (SPLIT_UNITS),
                .HI_MARGIN      (HI_MARGIN),
                .LO_MARGIN      (LO_MARGIN)
            ) u_bucket (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (win_restart),
                .add     (add_here),
                .len     (frame_len),
                .rate    (rate_sel[d*2+c]),
                .near    (near_f[d*2+c]),
                .over    (over_f[d*2+c])
            );
        end
    end

    // Output decode
    always_comb begin
        rx_block[0] = over_f[0];
        rx_block[1] = prio_en ? over_f[1] : over_f[0];
        tx_block[0] = over_f[2];
        tx_block[1] = prio_en ? over_f[3] : over_f[2];
        admit       = frame_start &&
                      !(frame_dir ? tx_block[frame_prio] : rx_block[frame_prio]);
        fc_req      = fc_en && (near_f[0] || near_f[1]);
    end

endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int WINDOW_TICKS = 1_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       frame_start,
    input logic       frame_dir,
    input logic       fc_en,
    input logic [1:0] rx_block,
    input logic [1:0] tx_block,
    input logic       fc_req,
    input logic       win_restart
);
    localparam int CW = $clog2(WINDOW_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_TICKS - 1);

    logic [CW-1:0] ck_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    ck_cnt <= '0;
        else if (tick) ck_cnt <= (ck_cnt == LAST) ? '0 : ck_cnt + 1'b1;
    end

    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_restart == (tick && (ck_cnt == LAST)));

    p_window_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_restart && !frame_start) |=> (rx_block == 2'b00 && tx_block == 2'b00 && !fc_req));

    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_block[0] && !win_restart) |=> rx_block[0]);

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_block[0] && !win_restart) |=> tx_block[0]);

    p_rx_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_block[0]) |-> $past(frame_start && !frame_dir));

    p_fc_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && rx_block[0]) |-> fc_req);

    p_fc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |-> !fc_req);

endmodule

bind port_rate_limiter rl_checker #(.WINDOW_TICKS(WINDOW_TICKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .frame_start (frame_start),
    .frame_dir   (frame_dir),
    .fc_en       (fc_en),
    .rx_block    (rx_block),
    .tx_block    (tx_block),
    .fc_req      (fc_req),
    .win_restart (win_restart)
);

// File: tb/port_rate_limiter_test.sv
module port_rate_limiter_test;

    localparam int WT = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        frame_start = 1'b0;
    logic        frame_dir = 1'b0;
    logic        frame_prio = 1'b0;
    logic [10:0] frame_len = '0;
    logic        prio_en = 1'b0;
    logic        fc_en = 1'b0;
    logic [11:0] rx_rate_lo = '0, rx_rate_hi = '0, tx_rate_lo = '0, tx_rate_hi = '0;
    logic        admit;
    logic [1:0]  rx_block, tx_block;
    logic        fc_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    port_rate_limiter #(.WINDOW_TICKS(WT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .frame_start(frame_start), .frame_dir(frame_dir), .frame_prio(frame_prio),
        .frame_len(frame_len), .prio_en(prio_en), .fc_en(fc_en),
        .rx_rate_lo(rx_rate_lo), .rx_rate_hi(rx_rate_hi),
        .tx_rate_lo(tx_rate_lo), .tx_rate_hi(tx_rate_hi),
        .admit(admit), .rx_block(rx_block), .tx_block(tx_block), .fc_req(fc_req)
    );

    // {dir, prio, len[10:0], admit, rx_block[1:0], tx_block[1:0], fc}
    // config: prio_en=1, fc_en=1, rx lo=1 (4000 B), rx hi=4 (16000 B), tx lo=2 (8000 B), tx hi=0
    localparam logic [18:0] VEC [21] = '{
        {1'b0, 1'b0, 11'd1500, 1'b1, 2'b00, 2'b00, 1'b0},
        {1'b0, 1'b0, 11'd1000, 1'b1, 2'b00, 2'b00, 1'b1},
        {1'b0, 1'b0, 11'd1500, 1'b1, 2'b00, 2'b00, 1'b1},
        {1'b0, 1'b0, 11'd64,   1'b1, 2'b01, 2'b00, 1'b1},
        {1'b0, 1'b0, 11'd100,  1'b0, 2'b01, 2'b00, 1'b1},
        {1'b0, 1'b1, 11'd2000, 1'b1, 2'b01, 2'b00, 1'b1},
        {1'b1, 1'b0, 11'd2000, 1'b1, 2'b01, 2'b00, 1'b1},
        {1'b1, 1'b0, 11'd2000, 1'b1, 2'b01, 2'b00, 1'b1},
        {1'b1, 1'b0, 11'd2000, 1'b1, 2'b01, 2'b00, 1'b1},
        {1'b1, 1'b0, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b1, 1'b0, 11'd10,   1'b0, 2'b01, 2'b01, 1'b1},
        {1'b1, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b1, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b01, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd2047, 1'b1, 2'b11, 2'b01, 1'b1},
        {1'b0, 1'b1, 11'd5,    1'b0, 2'b11, 2'b01, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frame_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Sends one frame; returns admit seen in its start cycle
    task automatic send(input logic dir, input logic prio, input int len, output logic adm);
        @(negedge clk);
        frame_start = 1'b1;
        frame_dir   = dir;
        frame_prio  = prio;
        frame_len   = 11'(len);
        #1 adm = admit;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic run();
        logic a;
        // R1 reset state
        do_reset();
        chk("R1 rx_block", int'(rx_block), 0);
        chk("R1 tx_block", int'(tx_block), 0);
        chk("R1 fc_req", int'(fc_req), 0);

        // Table walk: R4 R5 R6 R8 R10 R11
        prio_en = 1'b1; fc_en = 1'b1;
        rx_rate_lo = 12'd1; rx_rate_hi = 12'd4; tx_rate_lo = 12'd2; tx_rate_hi = 12'd0;
        do_reset();
        for (int i = 0; i < 21; i++) begin
            logic [18:0] v;
            v = VEC[i];
            send(v[18], v[17], int'(v[16:6]), a);
            chk($sformatf("R4 R5 R6 R8 R10 R11 entry %0d admit", i), int'(a), int'(v[5]));
            chk($sformatf("R4 R11 entry %0d rx_block", i), int'(rx_block), int'(v[4:3]));
            chk($sformatf("R5 R11 entry %0d tx_block", i), int'(tx_block), int'(v[2:1]));
            chk($sformatf("R8 entry %0d fc_req", i), int'(fc_req), int'(v[0]));
        end

        // R7 high margin, R12 single budget, R2 window clear
        prio_en = 1'b0; fc_en = 1'b1; rx_rate_lo = 12'd4; rx_rate_hi = 12'd1;
        do_reset();
        for (int k = 1; k <= 9; k++) begin
            send(1'b0, 1'b1, 2000, a);
            chk($sformatf("R12 frame %0d admit", k), int'(a), 1);
            if (k == 3) chk("R7 fc below margin", int'(fc_req), 0);
            if (k == 4) chk("R7 fc inside margin", int'(fc_req), 1);
            if (k == 8) chk("R6 equal budget no block", int'(rx_block), 0);
        end
        chk("R12 both bits blocked", int'(rx_block), 3);
        send(1'b0, 1'b0, 100, a);
        chk("R4 refused after overrun", int'(a), 0);
        repeat (2100) @(negedge clk);
        chk("R2 rx_block cleared", int'(rx_block), 0);
        chk("R2 fc_req cleared", int'(fc_req), 0);
        send(1'b0, 1'b0, 100, a);
        chk("R2 admitted in new window", int'(a), 1);

        // R9 flow control disabled
        fc_en = 1'b0;
        do_reset();
        for (int k = 0; k < 5; k++) send(1'b0, 1'b0, 2000, a);
        chk("R9 fc_req off", int'(fc_req), 0);

        // R10 unlimited
        rx_rate_lo = 12'd0; tx_rate_lo = 12'd0;
        do_reset();
        for (int k = 0; k < 12; k++) begin
            send(1'b0, 1'b0, 2047, a);
            chk("R10 rx admit", int'(a), 1);
        end
        chk("R10 rx_block", int'(rx_block), 0);

        // R3 exact window length in ticks
        tick = 1'b0; rx_rate_lo = 12'd1;
        do_reset();
        for (int k = 0; k < 3; k++) send(1'b0, 1'b0, 2047, a);
        chk("R3 blocked before ticks", int'(rx_block), 3);
        repeat (50) @(negedge clk);
        chk("R3 held without ticks", int'(rx_block), 3);
        tick = 1'b1;
        repeat (WT - 1) @(negedge clk);
        tick = 1'b0;
        chk("R3 held one tick early", int'(rx_block), 3);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R3 cleared on final tick", int'(rx_block), 0);
        tick = 1'b1;
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule